// File: doc/BRIEF.md
# System Control Coprocessor: Exception and Interrupt State

This block holds the privileged control state of a small 32-bit core. It has nine 32-bit control registers, each with its own write mask and reset value. It combines eight external interrupt lines with the interrupt-mask and mode bits of the status register to form one interrupt request to the core. When the pipeline signals an exception, the block records the cause code, the interrupt lines pending at that moment and the return address. It also sets the exception-level bit and presents the handler vector. An exception-return strobe leaves exception level, and the block supplies the stored return address as the resume PC.

Software reaches the registers through a move-to / move-from port, addressed by register number and select. Reads are combinational from the current register state. Writes, exception entry and exception return all take effect at the next rising clock edge.

Top module: `cp0_ctrl`

## Requirements
- R1: After reset, the EBase register (number 15, select 1) reads 0x80000000 and every other register reads zero.
- R2: A software write stores (old & ~mask) | (wdata & mask), visible on the next cycle. The masks are: UserLocal (4/2) 0xFFFFFFFF, EPC (14/0) 0xFFFFFFFF, EBase (15/1) 0xFFFFFFFC, and Status (12/0) 0x0000FF01, which covers IE (bit 0) and the interrupt mask (bits 15:8).
- R3: Writes to BadVAddr (8/0), Count (9/0), Compare (11/0), Cause (13/0) and Config (16/0) leave them unchanged.
- R4: A register number/select pair that is not listed in R2 or R3 reads zero. A write to such a pair changes no register.
- R5: `irq_req` is high exactly when some `irq_lines[k]` is high with Status bit 8+k set, while EXL (Status bit 1) and ERL (Status bit 2) are both clear. IE does not gate the request.
- R6: On exception entry, Status bit 1 is set. Cause is loaded with the 5-bit code in bits 6:2, `irq_lines` in bits 15:8 and the delay-slot flag in bit 31; all other Cause bits are zero. Codes: 1 interrupt, 4 load address error, 5 store address error, 6 instruction bus error, 7 data bus error, 8 syscall, 9 break, 12 overflow, 13 trap.
- R7: On exception entry, EPC is loaded with `exc_pc`, or with `exc_pc` - 4 when `exc_in_slot` is high.
- R8: `vector_addr` always equals EBase + 0x180. `redirect` is high in the same cycle as an exception entry with code 1 while EBase is non-zero, and is low otherwise.
- R9: An exception-return strobe clears EXL on the next cycle. `resume_pc` always equals EPC.
- R10: When events coincide in one cycle, exception entry takes priority over exception return, and exception return takes priority over a software write. The lower-priority event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_num | input | 5 | Register number for read and write |
| reg_sel | input | 3 | Register select for read and write |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Read data for the addressed register |
| irq_lines | input | 8 | External interrupt lines |
| exc_valid | input | 1 | Exception entry strobe |
| exc_code | input | 5 | Cause code of the exception |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_slot | input | 1 | Faulting instruction sits in a delay slot |
| eret | input | 1 | Exception return strobe |
| irq_req | output | 1 | Interrupt request to the core |
| vector_addr | output | 32 | Exception handler address |
| redirect | output | 1 | Take `vector_addr` as the next PC |
| resume_pc | output | 32 | Return address for exception return |

## Verification
The interrupt gate is driven with a single line under a matching mask, lines that fall outside the mask, all lines at once, and IE cleared. These patterns separate a correct per-line AND from an OR of the whole field, and show whether IE has been wrongly made a gate. Exception entries are tried in and out of a delay slot, with several codes and line patterns. This checks the EPC offset, the placement of each Cause field and the interrupt-only condition of the redirect. Cleared EBase, coinciding return/entry and coinciding write/entry cases confirm the vector condition and the priority order. Writes of all-ones to every register expose wrong masks and stray writes to unlisted addresses.

// File: rtl/cp0_pkg.sv
// cp0_pkg: shared types and constants for the control coprocessor.
// Assumes a 32-bit datapath and eight interrupt lines mapped to Status[15:8].
package cp0_pkg;
    localparam int XLEN      = 32;
    localparam int NUM_IRQ   = 8;
    localparam int CODE_W    = 5;
    localparam int IM_LSB    = 8;
    localparam int NREGS     = 10;
    localparam logic [XLEN-1:0] VEC_OFFSET = 32'h0000_0180;
    localparam int BIT_IE    = 0;
    localparam int BIT_EXL   = 1;
    localparam int BIT_ERL   = 2;
    localparam int BIT_SLOT  = 31;

    typedef enum logic [3:0] {
        RID_NONE, RID_ULOCAL, RID_BADVA, RID_COUNT, RID_COMPARE,
        RID_STATUS, RID_CAUSE, RID_EPC, RID_EBASE, RID_CONFIG
    } reg_id_e;

    typedef enum logic [CODE_W-1:0] {
        EC_NONE = 5'd0, EC_INT = 5'd1, EC_LOAD_ALIGN = 5'd4, EC_STORE_ALIGN = 5'd5,
        EC_IFETCH_BUS = 5'd6, EC_DATA_BUS = 5'd7, EC_SYSCALL = 5'd8,
        EC_BREAK = 5'd9, EC_OVERFLOW = 5'd12, EC_TRAP = 5'd13
    } exc_code_e;

    // Per-register software write mask.
    function automatic logic [XLEN-1:0] cp0_wmask(reg_id_e id);
        case (id)
            RID_ULOCAL, RID_EPC: return 32'hFFFF_FFFF;
            RID_STATUS:          return 32'h0000_FF01;
            RID_EBASE:           return 32'hFFFF_FFFC;
            default:             return '0;
        endcase
    endfunction

    // Per-register reset value.
    function automatic logic [XLEN-1:0] cp0_rstval(reg_id_e id);
        return (id == RID_EBASE) ? 32'h8000_0000 : '0;
    endfunction
endpackage

// File: rtl/cp0_map.sv
// cp0_map: turns a register number/select pair into an internal register id.
// Assumes unlisted pairs map to RID_NONE, which reads zero and never stores.
module cp0_map
    import cp0_pkg::*;
(
    input  logic [4:0] num,
    input  logic [2:0] sel,
    output reg_id_e    id
);
    // Address decode of the implemented pairs.
    always_comb begin
        case ({num, sel})
            {5'd4,  3'd2}: id = RID_ULOCAL;
            {5'd8,  3'd0}: id = RID_BADVA;
            {5'd9,  3'd0}: id = RID_COUNT;
            {5'd11, 3'd0}: id = RID_COMPARE;
            {5'd12, 3'd0}: id = RID_STATUS;
            {5'd13, 3'd0}: id = RID_CAUSE;
            {5'd14, 3'd0}: id = RID_EPC;
            {5'd15, 3'd1}: id = RID_EBASE;
            {5'd16, 3'd0}: id = RID_CONFIG;
            default:       id = RID_NONE;
        endcase
    end
endmodule

// File: rtl/cp0_irq_gate.sv
// cp0_irq_gate: forms the core interrupt request from the lines and Status.
// Assumes Status[8+k] masks line k; EXL or ERL blocks the request; IE is not used.
module cp0_irq_gate
    import cp0_pkg::*;
(
    input  logic [NUM_IRQ-1:0] lines,
    input  logic [XLEN-1:0]    status,
    output logic               req
);
    logic [NUM_IRQ-1:0] live;

    // Per-line masking followed by the mode gate.
    always_comb begin
        live = lines & status[IM_LSB +: NUM_IRQ];
        req  = (|live) && !status[BIT_EXL] && !status[BIT_ERL];
    end
endmodule

// File: rtl/cp0_ctrl.sv
// cp0_ctrl: control-register file with exception entry/return and vectoring.
// Assumes one event per cycle wins: exception entry, then return, then write.
module cp0_ctrl
    import cp0_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         reg_num,
    input  logic [2:0]         reg_sel,
    input  logic               wr_en,
    input  logic [XLEN-1:0]    wr_data,
    output logic [XLEN-1:0]    rd_data,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               exc_valid,
    input  logic [CODE_W-1:0]  exc_code,
    input  logic [XLEN-1:0]    exc_pc,
    input  logic               exc_in_slot,
    input  logic               eret,
    output logic               irq_req,
    output logic [XLEN-1:0]    vector_addr,
    output logic               redirect,
    output logic [XLEN-1:0]    resume_pc
);
    reg_id_e         addr_id;
    logic [XLEN-1:0] regs [NREGS];
    logic [XLEN-1:0] cause_entry;
    logic [XLEN-1:0] epc_entry;
    logic            sw_wr;

    cp0_map u_map (.num(reg_num), .sel(reg_sel), .id(addr_id));

    cp0_irq_gate u_gate (.lines(irq_lines), .status(regs[RID_STATUS]), .req(irq_req));

    // Values captured on exception entry and the gated software write.
    always_comb begin
        cause_entry = '0;
        cause_entry[BIT_SLOT] = exc_in_slot;
        cause_entry[IM_LSB +: NUM_IRQ] = irq_lines;
        cause_entry[2 +: CODE_W] = exc_code;
        epc_entry = exc_in_slot ? exc_pc - 32'd4 : exc_pc;
        sw_wr = wr_en && !exc_valid && !eret;
    end

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        localparam reg_id_e         ID   = reg_id_e'(gi);
        localparam logic [XLEN-1:0] MASK = cp0_wmask(ID);
        // Register update: reset, exception entry, return, then masked write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[gi] <= cp0_rstval(ID);
            else if (exc_valid && ID == RID_STATUS)
                regs[gi] <= regs[gi] | (32'd1 << BIT_EXL);
            else if (exc_valid && ID == RID_CAUSE)
                regs[gi] <= cause_entry;
            else if (exc_valid && ID == RID_EPC)
                regs[gi] <= epc_entry;
            else if (eret && !exc_valid && ID == RID_STATUS)
                regs[gi] <= regs[gi] & ~(32'd1 << BIT_EXL);
            else if (sw_wr && addr_id == ID)
                regs[gi] <= (regs[gi] & ~MASK) | (wr_data & MASK);
        end
    end

    // Read mux, vector and resume address.
    always_comb begin
        rd_data     = regs[addr_id];
        vector_addr = regs[RID_EBASE] + VEC_OFFSET;
        redirect    = exc_valid && (exc_code == EC_INT) && (regs[RID_EBASE] != '0);
        resume_pc   = regs[RID_EPC];
    end

    // R6
    exc_sets_exl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> regs[RID_STATUS][BIT_EXL]);
    // R9
    eret_clears_exl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_valid) |=> !regs[RID_STATUS][BIT_EXL]);
    // R7
    slot_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_in_slot) |=> resume_pc == $past(exc_pc) - 32'd4);
    // R5
    irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !regs[RID_STATUS][BIT_EXL] && !regs[RID_STATUS][BIT_ERL]);
    // R2
    ebase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs[RID_EBASE][1:0] == 2'b00);
    // R3
    config_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(regs[RID_CONFIG]));
    // R4
    none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs[RID_NONE] == '0);
endmodule

// File: tb/test_cp0_ctrl.sv
`timescale 1ns/1ps
module test_cp0_ctrl;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  reg_num = 0;
    logic [2:0]  reg_sel = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic [7:0]  irq_lines = 0;
    logic        exc_valid = 0;
    logic [4:0]  exc_code = 0;
    logic [31:0] exc_pc = 0;
    logic        exc_in_slot = 0;
    logic        eret = 0;
    logic        irq_req;
    logic [31:0] vector_addr;
    logic        redirect;
    logic [31:0] resume_pc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state
    bit [31:0] m_ul, m_bva, m_cnt, m_cmp, m_st, m_ca, m_epc, m_eb, m_cfg;

    always #2 clk = ~clk;

    cp0_ctrl i_cp0_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_lines(irq_lines), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_in_slot(exc_in_slot), .eret(eret),
        .irq_req(irq_req), .vector_addr(vector_addr), .redirect(redirect),
        .resume_pc(resume_pc));

    function automatic bit [31:0] m_read(bit [4:0] n, bit [2:0] s);
        if (n == 4 && s == 2) return m_ul;
        if (n == 8 && s == 0) return m_bva;
        if (n == 9 && s == 0) return m_cnt;
        if (n == 11 && s == 0) return m_cmp;
        if (n == 12 && s == 0) return m_st;
        if (n == 13 && s == 0) return m_ca;
        if (n == 14 && s == 0) return m_epc;
        if (n == 15 && s == 1) return m_eb;
        if (n == 16 && s == 0) return m_cfg;
        return 0;
    endfunction

    task automatic m_reset();
        m_ul = 0; m_bva = 0; m_cnt = 0; m_cmp = 0; m_st = 0;
        m_ca = 0; m_epc = 0; m_eb = 32'h8000_0000; m_cfg = 0;
    endtask

    task automatic cmp(string tag, string what, bit [31:0] act, bit [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance model at posedge.
    task automatic step(string tag, bit we, bit [4:0] n, bit [2:0] s, bit [31:0] wd,
                        bit [7:0] irq, bit ev, bit [4:0] code, bit [31:0] pc,
                        bit slot, bit er);
        bit exp_irq;
        reg_num = n; reg_sel = s; wr_en = we; wr_data = wd; irq_lines = irq;
        exc_valid = ev; exc_code = code; exc_pc = pc; exc_in_slot = slot; eret = er;
        #1;
        exp_irq = ((irq & m_st[15:8]) != 0) && !m_st[1] && !m_st[2];
        cmp(tag, "rd_data", rd_data, m_read(n, s));
        cmp(tag, "irq_req", {31'b0, irq_req}, {31'b0, exp_irq});
        cmp(tag, "vector_addr", vector_addr, m_eb + 32'h180);
        cmp(tag, "redirect", {31'b0, redirect}, {31'b0, ev && code == 1 && m_eb != 0});
        cmp(tag, "resume_pc", resume_pc, m_epc);
        @(posedge clk);
        if (ev) begin
            m_st = m_st | 32'h2;
            m_ca = {slot, 15'b0, irq, 1'b0, code, 2'b0};
            m_epc = slot ? pc - 4 : pc;
        end else if (er) begin
            m_st = m_st & ~32'h2;
        end else if (we) begin
            if (n == 4 && s == 2) m_ul = wd;
            if (n == 12 && s == 0) m_st = (m_st & ~32'hFF01) | (wd & 32'hFF01);
            if (n == 14 && s == 0) m_epc = wd;
            if (n == 15 && s == 1) m_eb = (m_eb & 32'h3) | (wd & 32'hFFFF_FFFC);
        end
        @(negedge clk);
    endtask

    task automatic rd(string tag, bit [4:0] n, bit [2:0] s);
        step(tag, 0, n, s, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(string tag, bit [4:0] n, bit [2:0] s, bit [31:0] d);
        step(tag, 1, n, s, d, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd("R1", 15, 1); rd("R1", 12, 0); rd("R1", 13, 0); rd("R1", 14, 0);
        rd("R1", 4, 2);  rd("R1", 16, 0);
        // R2 masked writes
        wr("R2", 4, 2, 32'hDEAD_BEEF);  rd("R2", 4, 2);
        wr("R2", 12, 0, 32'hFFFF_FFFF); rd("R2", 12, 0);
        wr("R2", 15, 1, 32'h1234_5677); rd("R2", 15, 1);
        wr("R2", 14, 0, 32'hA5A5_5A5A); rd("R2", 14, 0);
        // R3 read-only registers
        wr("R3", 8, 0, 32'hFFFF_FFFF);  rd("R3", 8, 0);
        wr("R3", 9, 0, 32'hFFFF_FFFF);  rd("R3", 9, 0);
        wr("R3", 11, 0, 32'hFFFF_FFFF); rd("R3", 11, 0);
        wr("R3", 13, 0, 32'hFFFF_FFFF); rd("R3", 13, 0);
        wr("R3", 16, 0, 32'hFFFF_FFFF); rd("R3", 16, 0);
        // R4 unlisted pairs
        wr("R4", 3, 0, 32'hFFFF_FFFF); rd("R4", 3, 0);
        wr("R4", 4, 0, 32'hFFFF_FFFF); rd("R4", 4, 0);
        wr("R4", 15, 0, 32'hFFFF_FFFF); rd("R4", 15, 1); rd("R4", 4, 2);
        // R5 interrupt gate patterns
        wr("R5", 12, 0, 32'h0000_0100);
        step("R5", 0, 12, 0, 0, 8'h01, 0, 0, 0, 0, 0);
        step("R5", 0, 12, 0, 0, 8'h02, 0, 0, 0, 0, 0);
        step("R5", 0, 12, 0, 0, 8'hFE, 0, 0, 0, 0, 0);
        wr("R5", 12, 0, 32'h0000_5A00);
        step("R5", 0, 12, 0, 0, 8'hA5, 0, 0, 0, 0, 0);
        step("R5", 0, 12, 0, 0, 8'h10, 0, 0, 0, 0, 0);
        step("R5", 0, 12, 0, 0, 8'hFF, 0, 0, 0, 0, 0);
        // R6 R7 exception entry, no slot, then gate blocked by EXL
        step("R6", 0, 13, 0, 0, 8'h10, 1, 5'd8, 32'h0000_4000, 0, 0);
        rd("R6", 13, 0); rd("R7", 14, 0); rd("R6", 12, 0);
        step("R5", 0, 12, 0, 0, 8'hFF, 0, 0, 0, 0, 0);
        // R9 exception return
        step("R9", 0, 12, 0, 0, 8'h10, 0, 0, 0, 0, 1);
        step("R9", 0, 12, 0, 0, 8'h10, 0, 0, 0, 0, 0);
        // R7 R8 interrupt entry from a delay slot
        step("R8", 0, 13, 0, 0, 8'h08, 1, 5'd1, 32'h0000_1000, 1, 0);
        rd("R7", 14, 0); rd("R6", 13, 0);
        step("R9", 0, 12, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R6", 0, 13, 0, 0, 8'h81, 1, 5'd13, 32'h0000_2008, 0, 0);
        rd("R6", 13, 0);
        step("R9", 0, 12, 0, 0, 0, 0, 0, 0, 0, 1);
        // R8 cleared EBase: no redirect
        wr("R8", 15, 1, 32'h0);
        step("R8", 0, 15, 1, 0, 8'h01, 1, 5'd1, 32'h0000_3000, 0, 0);
        step("R9", 0, 12, 0, 0, 0, 0, 0, 0, 0, 1);
        wr("R8", 15, 1, 32'h9000_0000);
        step("R8", 0, 15, 1, 0, 8'h01, 1, 5'd9, 32'h0000_3004, 0, 0);
        // R10 coinciding events
        step("R10", 0, 12, 0, 0, 0, 1, 5'd12, 32'h0000_5000, 0, 1);
        rd("R10", 12, 0);
        step("R10", 1, 14, 0, 32'h7777_0000, 0, 1, 5'd4, 32'h0000_6000, 0, 0);
        rd("R10", 14, 0);
        step("R10", 1, 4, 2, 32'h1111_2222, 0, 0, 0, 0, 0, 1);
        rd("R10", 4, 2); rd("R10", 12, 0);
        // R1 reset again
        rst_n = 0; m_reset(); @(negedge clk); rst_n = 1;
        rd("R1", 15, 1); rd("R1", 4, 2); rd("R1", 14, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule